// File: doc/BRIEF.md
# Shadow RAM segment attribute controller

This block is a chipset configuration unit that software reaches through a pair of I/O ports: one port latches a register index, the other reads or writes the register that index selects. From the stored configuration it decodes, for each upper-memory segment from C0000h up to FFFFFh, where reads are served (on-board DRAM or the external bus) and what happens to writes (sent to DRAM, sent to the external bus, or blocked). It also emits a one-cycle CPU soft-reset pulse, a reset-on-halt enable and an external-cache enable.

The I/O interface is a plain strobe interface rather than a valid/ready stream. Each `io_wr` or `io_rd` cycle completes in that cycle and the block never applies back-pressure. A read is combinational: `io_rdata` is valid in the same cycle as `io_rd`. The segment outputs are combinational from register state, so they reflect a data-port write from the first cycle after the clock edge that captures it.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: An `io_wr` to address 22h loads the index register. An access to address 24h reads or writes the register the index selects. Data-port accesses leave the index unchanged.
- R2: The register window covers indices 20h to 2Bh, with offset = index − 20h. `io_rdata` is FFh when the index is outside the window, when the address is not 24h, or when `io_rd` is low.
- R3: After reset the registers hold these values: offset 02h=84h, 04h=07h, 05h=F0h, 06h=30h, 07h=91h, 08h=80h, 09h=10h, 0Ah=80h, 0Bh=10h. Every other offset holds 00h.
- R4: At offset 00h only bits 5:0 take written data. Bits 7:6 keep their value.
- R5: A data write to offset 00h that changes bit 0 from 0 to 1 makes `soft_reset` high for exactly one cycle, starting in the cycle after the write. No other write produces the pulse.
- R6: `halt_reset_en` equals bit 1 of offset 00h. `ext_cache_en` equals bit 4 of offset 01h.
- R7: Segment 12 (F0000–FFFFF) decodes from bit 7 of offset 02h. When the bit is 1, reads use the bus and writes use DRAM. When the bit is 0, reads use DRAM and writes are blocked.
- R8: Segments 4..11 (D0000h, D4000h, … EC000h in 16 KB steps) are enabled by bits 0..7 of offset 03h. Segments 4..7 use offset 02h bit 5 as master and bit 3 as write-protect. Segments 8..11 use bit 6 as master and bit 4 as write-protect.
- R9: Segments 0..3 (C0000h … CC000h) are enabled by bits 0..3 of offset 06h. Their master is offset 06h bit 4 and their write-protect is bit 5.
- R10: The rule for segments 0..11 is applied in this order:
  - If the master and the enable are both set, reads use DRAM. Writes are blocked if write-protect is set; otherwise writes use DRAM.
  - Otherwise, if offset 06h bit 6 is set, reads use the bus and writes use DRAM.
  - Otherwise both reads and writes use the bus.
  - Segment i's fields are `seg_rd_src[2i+1:2i]` and `seg_wr_pol[2i+1:2i]`. The codes are DRAM=01, bus=10 and blocked=00.
- R11: Segment outputs reflect a data-port write in the first cycle after the edge that captures it.
- R12: A data-port write while the index is outside the window changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, FFh when nothing is selected |
| soft_reset | output | 1 | One-cycle CPU soft-reset pulse |
| halt_reset_en | output | 1 | Reset-on-halt enable |
| ext_cache_en | output | 1 | External cache enable |
| seg_rd_src | output | 26 | Read source, 2 bits per segment |
| seg_wr_pol | output | 26 | Write policy, 2 bits per segment |

## Verification
The embedded assertions check the following on every cycle:
- The index holds across data-port traffic.
- Bits 7:6 at offset 00h never change.
- The soft-reset pulse follows a qualifying write and lasts one cycle.
- Out-of-window writes change nothing.
- Every segment's codes stay legal, and a blocked write always comes with a DRAM read.

The precedence among master, enable, write-protect and the global write-to-DRAM bit, the exact reset image, and readback masking are shown only by the bench's scenarios. In those scenarios a reference model is compared against all 13 segments for each configuration.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam logic [1:0] SRC_DRAM = 2'b01;
  localparam logic [1:0] SRC_BUS  = 2'b10;
  localparam logic [1:0] WR_BLOCK = 2'b00;
  localparam logic [1:0] WR_DRAM  = 2'b01;
  localparam logic [1:0] WR_BUS   = 2'b10;

  typedef struct packed {
    logic [1:0] rd;
    logic [1:0] wr;
  } seg_attr_t;

  function automatic logic [7:0] reg_reset_value(input int unsigned off);
    case (off)
      2:  return 8'h84;
      4:  return 8'h07;
      5:  return 8'hF0;
      6:  return 8'h30;
      7:  return 8'h91;
      8:  return 8'h80;
      9:  return 8'h10;
      10: return 8'h80;
      11: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic seg_attr_t shadow_rule(input logic master, input logic en,
                                            input logic wp, input logic wr_dram);
    seg_attr_t a;
    if (master && en) begin
      a.rd = SRC_DRAM;
      a.wr = wp ? WR_BLOCK : WR_DRAM;
    end else if (wr_dram) begin
      a.rd = SRC_BUS;
      a.wr = WR_DRAM;
    end else begin
      a.rd = SRC_BUS;
      a.wr = WR_BUS;
    end
    return a;
  endfunction
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
  parameter int          NUM_REGS   = 12,
  parameter logic [7:0]  IDX_PORT   = 8'h22,
  parameter logic [7:0]  DATA_PORT  = 8'h24,
  parameter logic [7:0]  INDEX_BASE = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic                          io_rd,
  input  logic [7:0]                    io_addr,
  input  logic [7:0]                    io_wdata,
  output logic [7:0]                    io_rdata,
  output logic [NUM_REGS-1:0][7:0]      regs_o,
  output logic                          soft_reset_o
);
  import shadow_attr_pkg::*;

  localparam logic [7:0] INDEX_LAST = INDEX_BASE + 8'(NUM_REGS - 1);
  localparam logic [7:0] LOCK_MASK0 = 8'h3F;

  logic [7:0] index_q;
  logic [7:0] off;
  logic       in_window;
  logic       data_wr;
  logic       idx_wr;
  logic       pulse_q;
  logic [NUM_REGS-1:0][7:0] regs_q;

  assign in_window = (index_q >= INDEX_BASE) && (index_q <= INDEX_LAST);
  assign off       = index_q - INDEX_BASE;
  assign data_wr   = io_wr && (io_addr == DATA_PORT);
  assign idx_wr    = io_wr && (io_addr == IDX_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_wr) index_q <= io_wdata;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] WMASK = (g == 0) ? LOCK_MASK0 : 8'hFF;
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= reg_reset_value(g);
      else if (data_wr && in_window && (off == 8'(g)))
        regs_q[g] <= (regs_q[g] & ~WMASK) | (io_wdata & WMASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= data_wr && in_window && (off == 8'd0) &&
                           !regs_q[0][0] && io_wdata[0];
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && (io_addr == DATA_PORT) && in_window)
      for (int k = 0; k < NUM_REGS; k++)
        if (off == 8'(k)) io_rdata = regs_q[k];
  end

  assign regs_o       = regs_q;
  assign soft_reset_o = pulse_q;

  assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> $stable(index_q));
  assert_lock_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && in_window && off == 8'd0) |=> regs_q[0][7:6] == $past(regs_q[0][7:6]));
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(data_wr && io_wdata[0]));
  assert_oob_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !in_window) |=> $stable(regs_q));
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int C_SEGS  = 4,
  parameter int DE_SEGS = 8
) (
  input  logic [7:0]                       cfg_shadow,
  input  logic [7:0]                       cfg_enable,
  input  logic [7:0]                       cfg_low,
  output logic [2*(C_SEGS+DE_SEGS+1)-1:0]  rd_src,
  output logic [2*(C_SEGS+DE_SEGS+1)-1:0]  wr_pol
);
  import shadow_attr_pkg::*;

  localparam int NSEG    = C_SEGS + DE_SEGS + 1;
  localparam int TOP_SEG = NSEG - 1;
  localparam int HALF_DE = DE_SEGS / 2;

  logic wr_dram_all;
  assign wr_dram_all = cfg_low[6];

  for (genvar i = 0; i < C_SEGS; i++) begin : g_c
    seg_attr_t a;
    assign a = shadow_rule(cfg_low[4], cfg_low[i], cfg_low[5], wr_dram_all);
    assign rd_src[2*i +: 2] = a.rd;
    assign wr_pol[2*i +: 2] = a.wr;
  end

  for (genvar j = 0; j < DE_SEGS; j++) begin : g_de
    seg_attr_t a;
    if (j >= HALF_DE) begin : g_e
      assign a = shadow_rule(cfg_shadow[6], cfg_enable[j], cfg_shadow[4], wr_dram_all);
    end else begin : g_d
      assign a = shadow_rule(cfg_shadow[5], cfg_enable[j], cfg_shadow[3], wr_dram_all);
    end
    assign rd_src[2*(C_SEGS+j) +: 2] = a.rd;
    assign wr_pol[2*(C_SEGS+j) +: 2] = a.wr;
  end

  assign rd_src[2*TOP_SEG +: 2] = cfg_shadow[7] ? SRC_BUS : SRC_DRAM;
  assign wr_pol[2*TOP_SEG +: 2] = cfg_shadow[7] ? WR_DRAM : WR_BLOCK;
endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl #(
  parameter int         C_SEGS     = 4,
  parameter int         DE_SEGS    = 8,
  parameter int         NUM_REGS   = 12,
  parameter logic [7:0] IDX_PORT   = 8'h22,
  parameter logic [7:0] DATA_PORT  = 8'h24,
  parameter logic [7:0] INDEX_BASE = 8'h20
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 io_wr,
  input  logic                                 io_rd,
  input  logic [7:0]                           io_addr,
  input  logic [7:0]                           io_wdata,
  output logic [7:0]                           io_rdata,
  output logic                                 soft_reset,
  output logic                                 halt_reset_en,
  output logic                                 ext_cache_en,
  output logic [2*(C_SEGS+DE_SEGS+1)-1:0]      seg_rd_src,
  output logic [2*(C_SEGS+DE_SEGS+1)-1:0]      seg_wr_pol
);
  import shadow_attr_pkg::*;

  localparam int NSEG    = C_SEGS + DE_SEGS + 1;
  localparam int TOP_SEG = NSEG - 1;

  logic [NUM_REGS-1:0][7:0] regs;

  shadow_cfg_regs #(
    .NUM_REGS(NUM_REGS), .IDX_PORT(IDX_PORT),
    .DATA_PORT(DATA_PORT), .INDEX_BASE(INDEX_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .regs_o(regs), .soft_reset_o(soft_reset)
  );

  shadow_seg_decode #(.C_SEGS(C_SEGS), .DE_SEGS(DE_SEGS)) u_decode (
    .cfg_shadow(regs[2]), .cfg_enable(regs[3]), .cfg_low(regs[6]),
    .rd_src(seg_rd_src), .wr_pol(seg_wr_pol)
  );

  assign halt_reset_en = regs[0][1];
  assign ext_cache_en  = regs[1][4];

  for (genvar s = 0; s < NSEG; s++) begin : g_chk
    assert_legal_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_rd_src[2*s +: 2] == SRC_DRAM) || (seg_rd_src[2*s +: 2] == SRC_BUS));
    assert_blocked_reads_dram_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_wr_pol[2*s +: 2] == WR_BLOCK) |-> (seg_rd_src[2*s +: 2] == SRC_DRAM));
  end

  assert_top_seg_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_rd_src[2*TOP_SEG +: 2] == SRC_BUS) |-> (seg_wr_pol[2*TOP_SEG +: 2] == WR_DRAM));
endmodule

// File: tb/shadow_attr_ctrl_tb.sv
module shadow_attr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        soft_reset, halt_reset_en, ext_cache_en;
  logic [25:0] seg_rd_src, seg_wr_pol;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  shadow_attr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .soft_reset(soft_reset), .halt_reset_en(halt_reset_en),
    .ext_cache_en(ext_cache_en), .seg_rd_src(seg_rd_src), .seg_wr_pol(seg_wr_pol)
  );

  // stimulus vectors {offset02, offset03, offset06}
  localparam logic [23:0] VEC [8] = '{
    24'h00_00_00, 24'h80_FF_00, 24'h60_FF_1F, 24'h78_FF_3F,
    24'h40_F0_10, 24'h20_0F_50, 24'h48_5A_65, 24'h10_FF_4F
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] off, input logic [7:0] d);
    io_write(8'h22, 8'h20 + off);
    io_write(8'h24, d);
  endtask

  // reference: DRAM=01 bus=10 blocked=00
  function automatic logic [51:0] model(input logic [7:0] r2, input logic [7:0] r3,
                                        input logic [7:0] r6);
    logic [25:0] rd, wr;
    for (int s = 0; s < 12; s++) begin
      logic m, e, p;
      if (s < 4)      begin m = r6[4]; e = r6[s];   p = r6[5]; end
      else if (s < 8) begin m = r2[5]; e = r3[s-4]; p = r2[3]; end
      else            begin m = r2[6]; e = r3[s-4]; p = r2[4]; end
      if (m && e)      begin rd[2*s +: 2] = 2'b01; wr[2*s +: 2] = p ? 2'b00 : 2'b01; end
      else if (r6[6])  begin rd[2*s +: 2] = 2'b10; wr[2*s +: 2] = 2'b01; end
      else             begin rd[2*s +: 2] = 2'b10; wr[2*s +: 2] = 2'b10; end
    end
    rd[25:24] = r2[7] ? 2'b10 : 2'b01;
    wr[25:24] = r2[7] ? 2'b01 : 2'b00;
    return {rd, wr};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [51:0] exp_seg;
    logic [25:0] snap_rd, snap_wr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset image and reset decode
    @(negedge clk);
    chk("R3 soft_reset", 32'(soft_reset), 0);
    exp_seg = model(8'h84, 8'h00, 8'h30);
    chk("R3 rd reset", 32'(seg_rd_src), 32'(exp_seg[51:26]));
    chk("R3 wr reset", 32'(seg_wr_pol), 32'(exp_seg[25:0]));
    for (int k = 0; k < 12; k++) begin
      logic [7:0] rv;
      case (k)
        2: rv = 8'h84; 4: rv = 8'h07; 5: rv = 8'hF0; 6: rv = 8'h30;
        7: rv = 8'h91; 8: rv = 8'h80; 9: rv = 8'h10; 10: rv = 8'h80;
        11: rv = 8'h10; default: rv = 8'h00;
      endcase
      io_write(8'h22, 8'h20 + 8'(k));
      io_read(8'h24, d);
      chk("R3 reset value", 32'(d), 32'(rv));
    end

    // R7 R8 R9 R10 R11 table walk, checked the cycle after the last write
    for (int v = 0; v < 8; v++) begin
      reg_write(8'h02, VEC[v][23:16]);
      reg_write(8'h03, VEC[v][15:8]);
      reg_write(8'h06, VEC[v][7:0]);
      exp_seg = model(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      chk("R7 R8 R9 R10 R11 rd", 32'(seg_rd_src), 32'(exp_seg[51:26]));
      chk("R7 R8 R9 R10 R11 wr", 32'(seg_wr_pol), 32'(exp_seg[25:0]));
    end

    // R1 index persists across data accesses
    reg_write(8'h05, 8'hA5);
    io_write(8'h24, 8'h5A);
    io_read(8'h24, d);
    chk("R1 index held", 32'(d), 32'h5A);

    // R2 out-of-window and wrong port reads
    io_read(8'h23, d);
    chk("R2 other port", 32'(d), 32'hFF);
    io_write(8'h22, 8'h2C);
    io_read(8'h24, d);
    chk("R2 above window", 32'(d), 32'hFF);
    io_write(8'h22, 8'h1F);
    io_read(8'h24, d);
    chk("R2 below window", 32'(d), 32'hFF);
    io_write(8'h22, 8'h2B);
    io_read(8'h24, d);
    chk("R2 last in window", 32'(d), 32'h10);

    // R12 writes outside window do nothing
    reg_write(8'h02, 8'h80);
    snap_rd = seg_rd_src; snap_wr = seg_wr_pol;
    io_write(8'h22, 8'h2C); io_write(8'h24, 8'h00);
    io_write(8'h22, 8'h1F); io_write(8'h24, 8'h00);
    chk("R12 rd unchanged", 32'(seg_rd_src), 32'(snap_rd));
    chk("R12 wr unchanged", 32'(seg_wr_pol), 32'(snap_wr));
    io_write(8'h22, 8'h22);
    io_read(8'h24, d);
    chk("R12 reg unchanged", 32'(d), 32'h80);

    // R6 status outputs
    reg_write(8'h01, 8'h10);
    chk("R6 ext_cache_en", 32'(ext_cache_en), 1);
    reg_write(8'h00, 8'h02);
    chk("R6 halt_reset_en", 32'(halt_reset_en), 1);
    chk("R5 no pulse bit0 low", 32'(soft_reset), 0);

    // R5 pulse on 0->1 of bit0
    io_write(8'h24, 8'h01);
    chk("R5 pulse high", 32'(soft_reset), 1);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(soft_reset), 0);
    io_write(8'h24, 8'h01);
    chk("R5 no pulse when already set", 32'(soft_reset), 0);

    // R4 bits 7:6 locked
    io_write(8'h24, 8'hFF);
    chk("R5 no pulse on FF", 32'(soft_reset), 0);
    io_read(8'h24, d);
    chk("R4 locked bits", 32'(d), 32'h3F);
    chk("R6 halt after FF", 32'(halt_reset_en), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule